// File: doc/BRIEF.md
# Microcode-Lockable Dual-Port RAM

This block is a shared on-chip RAM with two synchronous ports. The host port serves a processor or DMA engine through a plain enable/write-enable/address/data bus. The controller port serves an embedded communications controller, which uses it to read data and to fetch microcode. The address space is 2048 words of 32 bits. Byte offsets in this brief are four times the word address.

| Word range | Byte range | Region |
|---|---|---|
| 0x000–0x3FF | 0x0000–0x0FFF | system RAM |
| 0x400–0x6FF | 0x1000–0x1BFF | unimplemented hole |
| 0x700–0x7FF | 0x1C00–0x1FFF | parameter RAM |

A 2-bit microcode-enable field is loaded through `cfg_we`/`cfg_mode`. It sets which parts of system RAM are reserved for microcode. While a region is reserved, host reads of it return all ones and host writes to it are discarded without any error indication. The controller port keeps full access to all implemented memory.

The reservation is held in a four-state machine. Its states are named after the encoding that selects them:

| State | Encoding | Effect |
|---|---|---|
| MODE_OPEN | 00 | no reservation; reset state |
| MODE_ONE | 01 | one 512-byte block reserved |
| MODE_TWO | 10 | two 512-byte blocks reserved |
| MODE_FOUR | 11 | four 512-byte blocks reserved |

There is one transition rule. In any cycle with `cfg_we` high, the machine moves from any state to the state named by `cfg_mode`. That includes staying in the current state. With `cfg_we` low, the state holds.

Top module: `dpr_ucode_ram`

## Requirements
- R1: After reset the state is MODE_OPEN, and both `hst_rdata` and `ctl_rdata` are zero.
- R2: In MODE_OPEN (encoding 00), no system-RAM word is locked. The host reads back what it wrote anywhere in words 0x000–0x3FF.
- R3: In MODE_ONE (encoding 01), host reads of words 0x000–0x07F and 0x3C0–0x3FF return all ones. Those are bytes 0x000–0x1FF and 0xF00–0xFFF.
- R4: In MODE_TWO (encoding 10), host reads of words 0x000–0x0FF and 0x3C0–0x3FF return all ones.
- R5: In MODE_FOUR (encoding 11), host reads of words 0x000–0x1FF and 0x380–0x3FF return all ones. Those are bytes 0x000–0x7FF and 0xE00–0xFFF.
- R6: Words 0x200–0x37F (bytes 0x800–0xDFF) are never locked in any mode.
- R7: A host write to a locked word leaves its content unchanged.
- R8: The controller port reads and writes locked words normally in every mode.
- R9: Words 0x400–0x6FF are unimplemented. Reads there return all ones on both ports, and writes there have no effect.
- R10: Parameter RAM at words 0x700–0x7FF is readable and writable from both ports.
- R11: Read data appears on the clock edge after the read request. Each port's read data holds its value until that port's next read.
- R12: When both ports write the same word in the same cycle, the controller's data is stored.
- R13: A `cfg_we` pulse changes the lock map for host requests made from the next cycle on. A host request in the same cycle as the pulse uses the old map.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Load the microcode-enable field |
| cfg_mode | input | 2 | Microcode-enable encoding (00/01/10/11) |
| hst_en | input | 1 | Host access request |
| hst_we | input | 1 | Host write (1) or read (0) |
| hst_addr | input | 11 | Host word address |
| hst_wdata | input | 32 | Host write data |
| hst_rdata | output | 32 | Host read data, one cycle after the request |
| ctl_en | input | 1 | Controller access request |
| ctl_we | input | 1 | Controller write (1) or read (0) |
| ctl_addr | input | 11 | Controller word address |
| ctl_wdata | input | 32 | Controller write data |
| ctl_rdata | output | 32 | Controller read data, one cycle after the request |

## Verification
Every read result is due exactly one rising edge after the cycle that presents the request. A mode load is due for host requests presented in the cycle after the `cfg_we` pulse. The bench drives each request at a falling edge and samples one nanosecond after the following rising edge, so every sample falls in the cycle the result is due. For R13, the host read and the mode load are presented in the same cycle, and the read is expected to return the old, unlocked data. The next read is expected to return all ones. For R11, the bench idles for several cycles and confirms that both read-data outputs stay unchanged.

// File: rtl/dpr_ucode_pkg.sv
package dpr_ucode_pkg;

    // Microcode reservation state; encodings match the configuration field.
    typedef enum logic [1:0] {
        MODE_OPEN = 2'b00,
        MODE_ONE  = 2'b01,
        MODE_TWO  = 2'b10,
        MODE_FOUR = 2'b11
    } ucode_mode_e;

endpackage

// File: rtl/dpr_mode_fsm.sv
module dpr_mode_fsm
    import dpr_ucode_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_we,
    input  logic [1:0]  cfg_mode,
    output ucode_mode_e mode
);

    ucode_mode_e state_q, state_d;

    // Next-state logic: any state moves to the encoded state on a load.
    always_comb begin
        state_d = state_q;
        if (cfg_we) begin
            unique case (cfg_mode)
                2'b00:   state_d = MODE_OPEN;
                2'b01:   state_d = MODE_ONE;
                2'b10:   state_d = MODE_TWO;
                default: state_d = MODE_FOUR;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= MODE_OPEN;
        else        state_q <= state_d;
    end

    always_comb mode = state_q;

    a_r13_load_applies: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (state_q == ucode_mode_e'($past(cfg_mode))));

    a_r13_hold_without_load: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable(state_q));

endmodule

// File: rtl/dpr_addr_dec.sv
module dpr_addr_dec #(
    parameter int ADDR_W      = 11,
    parameter int SYS_WORDS   = 1024,
    parameter int PARAM_BASE  = 1792,
    parameter int PARAM_WORDS = 256,
    parameter int IDX_W       = 11
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              valid,
    output logic [IDX_W-1:0]  idx
);

    localparam logic [ADDR_W:0] SYS_END = (ADDR_W+1)'(SYS_WORDS);
    localparam logic [ADDR_W:0] PRM_LO  = (ADDR_W+1)'(PARAM_BASE);
    localparam logic [ADDR_W:0] PRM_HI  = (ADDR_W+1)'(PARAM_BASE + PARAM_WORDS);

    logic [ADDR_W:0] a_ext;
    logic            in_sys, in_prm;
    logic [ADDR_W:0] prm_off;

    always_comb begin
        a_ext   = {1'b0, addr};
        in_sys  = a_ext < SYS_END;
        in_prm  = (a_ext >= PRM_LO) && (a_ext < PRM_HI);
        prm_off = a_ext - PRM_LO + SYS_END;
        valid   = in_sys || in_prm;
        idx     = in_sys ? IDX_W'(a_ext) : IDX_W'(prm_off);
    end

endmodule

// File: rtl/dpr_lock_map.sv
module dpr_lock_map
    import dpr_ucode_pkg::*;
#(
    parameter int ADDR_W      = 11,
    parameter int SYS_WORDS   = 1024,
    parameter int BLOCK_WORDS = 128,
    parameter int TAIL_WORDS  = 64
) (
    input  ucode_mode_e       mode,
    input  logic [ADDR_W-1:0] addr,
    output logic              locked
);

    localparam logic [ADDR_W:0] SYS_END   = (ADDR_W+1)'(SYS_WORDS);
    localparam logic [ADDR_W:0] HEAD_ONE  = (ADDR_W+1)'(BLOCK_WORDS);
    localparam logic [ADDR_W:0] HEAD_TWO  = (ADDR_W+1)'(2 * BLOCK_WORDS);
    localparam logic [ADDR_W:0] HEAD_FOUR = (ADDR_W+1)'(4 * BLOCK_WORDS);
    localparam logic [ADDR_W:0] TAIL_NARROW = (ADDR_W+1)'(SYS_WORDS - TAIL_WORDS);
    localparam logic [ADDR_W:0] TAIL_WIDE   = (ADDR_W+1)'(SYS_WORDS - BLOCK_WORDS);

    logic [ADDR_W:0] a_ext, head_end, tail_lo;
    logic            any;

    always_comb begin
        a_ext    = {1'b0, addr};
        any      = 1'b1;
        head_end = '0;
        tail_lo  = SYS_END;
        unique case (mode)
            MODE_OPEN: any = 1'b0;
            MODE_ONE:  begin head_end = HEAD_ONE;  tail_lo = TAIL_NARROW; end
            MODE_TWO:  begin head_end = HEAD_TWO;  tail_lo = TAIL_NARROW; end
            MODE_FOUR: begin head_end = HEAD_FOUR; tail_lo = TAIL_WIDE;   end
        endcase
        locked = any && ((a_ext < head_end) ||
                         ((a_ext >= tail_lo) && (a_ext < SYS_END)));
    end

endmodule

// File: rtl/dpr_storage.sv
module dpr_storage #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 1280,
    parameter int IDX_W  = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_we,
    input  logic              a_re,
    input  logic [IDX_W-1:0]  a_idx,
    input  logic [DATA_W-1:0] a_wdata,
    output logic [DATA_W-1:0] a_q,
    input  logic              b_we,
    input  logic              b_re,
    input  logic [IDX_W-1:0]  b_idx,
    input  logic [DATA_W-1:0] b_wdata,
    output logic [DATA_W-1:0] b_q
);

    logic [DATA_W-1:0] mem [DEPTH];

    // Port B is written last, so it wins a same-word collision (R12).
    always_ff @(posedge clk) begin
        if (a_we) mem[a_idx] <= a_wdata;
        if (b_we) mem[b_idx] <= b_wdata;
    end

    // Read-first registered outputs, held between reads.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q <= '0;
            b_q <= '0;
        end else begin
            if (a_re) a_q <= mem[a_idx];
            if (b_re) b_q <= mem[b_idx];
        end
    end

endmodule

// File: rtl/dpr_ucode_ram.sv
module dpr_ucode_ram
    import dpr_ucode_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int ADDR_W      = 11,
    parameter int SYS_WORDS   = 1024,
    parameter int BLOCK_WORDS = 128,
    parameter int TAIL_WORDS  = 64,
    parameter int PARAM_BASE  = 1792,
    parameter int PARAM_WORDS = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_mode,
    input  logic              hst_en,
    input  logic              hst_we,
    input  logic [ADDR_W-1:0] hst_addr,
    input  logic [DATA_W-1:0] hst_wdata,
    output logic [DATA_W-1:0] hst_rdata,
    input  logic              ctl_en,
    input  logic              ctl_we,
    input  logic [ADDR_W-1:0] ctl_addr,
    input  logic [DATA_W-1:0] ctl_wdata,
    output logic [DATA_W-1:0] ctl_rdata
);

    localparam int DEPTH = SYS_WORDS + PARAM_WORDS;
    localparam int IDX_W = $clog2(DEPTH);
    localparam logic [ADDR_W:0] HOLE_LO = (ADDR_W+1)'(SYS_WORDS);
    localparam logic [ADDR_W:0] HOLE_HI = (ADDR_W+1)'(PARAM_BASE);
    localparam logic [ADDR_W:0] WIN_LO  = (ADDR_W+1)'(4 * BLOCK_WORDS);
    localparam logic [ADDR_W:0] WIN_HI  = (ADDR_W+1)'(SYS_WORDS - BLOCK_WORDS);

    ucode_mode_e       mode;
    logic              hst_valid, ctl_valid, hst_lock;
    logic [IDX_W-1:0]  hst_idx, ctl_idx;
    logic              hst_rd, ctl_rd, hst_wr_ok, ctl_wr_ok;
    logic              hst_mask_q, ctl_mask_q;
    logic [DATA_W-1:0] hst_q, ctl_q;

    dpr_mode_fsm u_mode (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_mode(cfg_mode), .mode(mode)
    );

    dpr_addr_dec #(.ADDR_W(ADDR_W), .SYS_WORDS(SYS_WORDS), .PARAM_BASE(PARAM_BASE),
                   .PARAM_WORDS(PARAM_WORDS), .IDX_W(IDX_W)) u_hst_dec (
        .addr(hst_addr), .valid(hst_valid), .idx(hst_idx)
    );

    dpr_addr_dec #(.ADDR_W(ADDR_W), .SYS_WORDS(SYS_WORDS), .PARAM_BASE(PARAM_BASE),
                   .PARAM_WORDS(PARAM_WORDS), .IDX_W(IDX_W)) u_ctl_dec (
        .addr(ctl_addr), .valid(ctl_valid), .idx(ctl_idx)
    );

    dpr_lock_map #(.ADDR_W(ADDR_W), .SYS_WORDS(SYS_WORDS), .BLOCK_WORDS(BLOCK_WORDS),
                   .TAIL_WORDS(TAIL_WORDS)) u_lock (
        .mode(mode), .addr(hst_addr), .locked(hst_lock)
    );

    always_comb begin
        hst_rd    = hst_en && !hst_we;
        ctl_rd    = ctl_en && !ctl_we;
        hst_wr_ok = hst_en && hst_we && hst_valid && !hst_lock;
        ctl_wr_ok = ctl_en && ctl_we && ctl_valid;
    end

    dpr_storage #(.DATA_W(DATA_W), .DEPTH(DEPTH), .IDX_W(IDX_W)) u_mem (
        .clk(clk), .rst_n(rst_n),
        .a_we(hst_wr_ok), .a_re(hst_rd && hst_valid && !hst_lock),
        .a_idx(hst_idx), .a_wdata(hst_wdata), .a_q(hst_q),
        .b_we(ctl_wr_ok), .b_re(ctl_rd && ctl_valid),
        .b_idx(ctl_idx), .b_wdata(ctl_wdata), .b_q(ctl_q)
    );

    // Per-read mask flags: all ones for locked or unimplemented words.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hst_mask_q <= 1'b0;
            ctl_mask_q <= 1'b0;
        end else begin
            if (hst_rd) hst_mask_q <= !hst_valid || hst_lock;
            if (ctl_rd) ctl_mask_q <= !ctl_valid;
        end
    end

    always_comb begin
        hst_rdata = hst_mask_q ? '1 : hst_q;
        ctl_rdata = ctl_mask_q ? '1 : ctl_q;
    end

    a_r2_open_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_OPEN) |-> !hst_lock);

    a_r6_window_free: assert property (@(posedge clk) disable iff (!rst_n)
        (({1'b0, hst_addr} >= WIN_LO) && ({1'b0, hst_addr} < WIN_HI)) |-> !hst_lock);

    a_r9_ctl_hole_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_rd && ({1'b0, ctl_addr} >= HOLE_LO) && ({1'b0, ctl_addr} < HOLE_HI))
        |=> (ctl_rdata == '1));

    a_r11_hst_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !hst_rd |=> $stable(hst_rdata));

    a_r11_ctl_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_rd |=> $stable(ctl_rdata));

endmodule

// File: tb/dpr_ucode_ram_bench.sv
module dpr_ucode_ram_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_mode = 2'b00;
    logic        hst_en = 1'b0, hst_we = 1'b0;
    logic [10:0] hst_addr = '0;
    logic [31:0] hst_wdata = '0, hst_rdata;
    logic        ctl_en = 1'b0, ctl_we = 1'b0;
    logic [10:0] ctl_addr = '0;
    logic [31:0] ctl_wdata = '0, ctl_rdata;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    dpr_ucode_ram u_dpr_ucode_ram (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_mode(cfg_mode),
        .hst_en(hst_en), .hst_we(hst_we), .hst_addr(hst_addr),
        .hst_wdata(hst_wdata), .hst_rdata(hst_rdata),
        .ctl_en(ctl_en), .ctl_we(ctl_we), .ctl_addr(ctl_addr),
        .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata)
    );

    typedef struct packed {
        logic [1:0]  mode;
        logic [10:0] addr;
        logic        lock;
        logic [3:0]  req;
    } vec_t;

    // Lock-map vectors: R2 (00), R3 (01), R4 (10), R5 (11), R6 window.
    localparam vec_t VECS [18] = '{
        '{2'b00, 11'h000, 1'b0, 4'd2}, '{2'b00, 11'h3FF, 1'b0, 4'd2},
        '{2'b01, 11'h07F, 1'b1, 4'd3}, '{2'b01, 11'h080, 1'b0, 4'd3},
        '{2'b01, 11'h3BF, 1'b0, 4'd3}, '{2'b01, 11'h3C0, 1'b1, 4'd3},
        '{2'b01, 11'h3FF, 1'b1, 4'd3},
        '{2'b10, 11'h0FF, 1'b1, 4'd4}, '{2'b10, 11'h100, 1'b0, 4'd4},
        '{2'b10, 11'h3BF, 1'b0, 4'd4}, '{2'b10, 11'h3C0, 1'b1, 4'd4},
        '{2'b11, 11'h1FF, 1'b1, 4'd5}, '{2'b11, 11'h380, 1'b1, 4'd5},
        '{2'b11, 11'h3FF, 1'b1, 4'd5},
        '{2'b11, 11'h200, 1'b0, 4'd6}, '{2'b11, 11'h37F, 1'b0, 4'd6},
        '{2'b01, 11'h37F, 1'b0, 4'd6}, '{2'b10, 11'h200, 1'b0, 4'd6}
    };

    function automatic logic [31:0] pat(input logic [10:0] a);
        return 32'h5A5A_0000 ^ {21'b0, a};
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic set_mode(input logic [1:0] m);
        @(negedge clk);
        cfg_we = 1'b1; cfg_mode = m;
        @(posedge clk); #1;
        cfg_we = 1'b0;
    endtask

    task automatic hwr(input logic [10:0] a, input logic [31:0] d);
        @(negedge clk);
        hst_en = 1'b1; hst_we = 1'b1; hst_addr = a; hst_wdata = d;
        @(posedge clk); #1;
        hst_en = 1'b0; hst_we = 1'b0;
    endtask

    task automatic cwr(input logic [10:0] a, input logic [31:0] d);
        @(negedge clk);
        ctl_en = 1'b1; ctl_we = 1'b1; ctl_addr = a; ctl_wdata = d;
        @(posedge clk); #1;
        ctl_en = 1'b0; ctl_we = 1'b0;
    endtask

    task automatic hrd(input logic [10:0] a, output logic [31:0] q);
        @(negedge clk);
        hst_en = 1'b1; hst_we = 1'b0; hst_addr = a;
        @(posedge clk); #1;
        q = hst_rdata;
        hst_en = 1'b0;
    endtask

    task automatic crd(input logic [10:0] a, output logic [31:0] q);
        @(negedge clk);
        ctl_en = 1'b1; ctl_we = 1'b0; ctl_addr = a;
        @(posedge clk); #1;
        q = ctl_rdata;
        ctl_en = 1'b0;
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] q;
        repeat (3) @(posedge clk);
        #1;
        check("R1 hst_rdata", hst_rdata, 32'h0);
        check("R1 ctl_rdata", ctl_rdata, 32'h0);
        rst_n = 1'b1;

        // Preload system and parameter RAM from the host while unlocked.
        for (int a = 0; a < 1024; a++) hwr(11'(a), pat(11'(a)));
        for (int a = 1792; a < 2048; a++) hwr(11'(a), pat(11'(a)));

        // R1: reset state is MODE_OPEN, so word 0 is host-visible.
        hrd(11'h000, q); check("R1 open after reset", q, pat(11'h000));

        foreach (VECS[i]) begin
            set_mode(VECS[i].mode);
            hrd(VECS[i].addr, q);
            check($sformatf("R%0d mode %b addr %h", VECS[i].req, VECS[i].mode, VECS[i].addr),
                  q, VECS[i].lock ? 32'hFFFF_FFFF : pat(VECS[i].addr));
        end

        // R7 / R8: locked words under MODE_FOUR.
        set_mode(2'b11);
        hwr(11'h010, 32'hDEAD_0001);
        crd(11'h010, q); check("R7 locked host write dropped", q, pat(11'h010));
        cwr(11'h011, 32'hC0FF_EE11);
        crd(11'h011, q); check("R8 ctl write locked word", q, 32'hC0FF_EE11);
        hrd(11'h011, q); check("R8 host still sees ones", q, 32'hFFFF_FFFF);
        crd(11'h3F0, q); check("R8 ctl reads locked tail", q, pat(11'h3F0));
        set_mode(2'b00);
        hrd(11'h011, q); check("R8 unlocked host sees ctl data", q, 32'hC0FF_EE11);
        hrd(11'h010, q); check("R7 unlocked content unchanged", q, pat(11'h010));

        // R9: hole.
        hrd(11'h400, q); check("R9 host hole low", q, 32'hFFFF_FFFF);
        hwr(11'h500, 32'h1234_5678);
        hrd(11'h500, q); check("R9 host hole write", q, 32'hFFFF_FFFF);
        cwr(11'h6FF, 32'h1111_2222);
        crd(11'h6FF, q); check("R9 ctl hole high", q, 32'hFFFF_FFFF);
        crd(11'h000, q); check("R9 hole write touched nothing", q, pat(11'h000));

        // R10: parameter RAM from both ports, also under MODE_FOUR.
        set_mode(2'b11);
        crd(11'h700, q); check("R10 ctl reads param", q, pat(11'h700));
        hwr(11'h7FF, 32'hAB00_07FF);
        crd(11'h7FF, q); check("R10 ctl sees host param write", q, 32'hAB00_07FF);
        cwr(11'h780, 32'h7788_9900);
        hrd(11'h780, q); check("R10 host sees ctl param write", q, 32'h7788_9900);

        // R11: outputs hold without reads.
        hrd(11'h300, q);
        crd(11'h301, q);
        repeat (4) @(posedge clk);
        #1;
        check("R11 host hold", hst_rdata, pat(11'h300));
        check("R11 ctl hold", ctl_rdata, pat(11'h301));

        // R12: same-word collision, controller wins.
        @(negedge clk);
        hst_en = 1'b1; hst_we = 1'b1; hst_addr = 11'h250; hst_wdata = 32'hAAAA_0250;
        ctl_en = 1'b1; ctl_we = 1'b1; ctl_addr = 11'h250; ctl_wdata = 32'hBBBB_0250;
        @(posedge clk); #1;
        hst_en = 1'b0; hst_we = 1'b0; ctl_en = 1'b0; ctl_we = 1'b0;
        hrd(11'h250, q); check("R12 controller wins", q, 32'hBBBB_0250);

        // R13: load and read in the same cycle use the old map.
        set_mode(2'b00);
        @(negedge clk);
        cfg_we = 1'b1; cfg_mode = 2'b11;
        hst_en = 1'b1; hst_we = 1'b0; hst_addr = 11'h001;
        @(posedge clk); #1;
        q = hst_rdata;
        cfg_we = 1'b0; hst_en = 1'b0;
        check("R13 same-cycle old map", q, pat(11'h001));
        hrd(11'h001, q); check("R13 next cycle new map", q, 32'hFFFF_FFFF);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule